// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor whose datapath takes several short clock cycles per instruction. It is a Moore state machine. Each cycle it presents one set of datapath controls: program-counter load, conditional program-counter load, memory address source, memory read, memory write, register write-back source, instruction-register load, register-file write, destination field select, ALU operand selects, ALU mode and next-PC source. The 6-bit opcode field of the instruction register picks the path after the decode step.

Five instruction classes are sequenced: register-to-register arithmetic, load word, store word, branch-if-equal and jump. Each class takes 3 to 5 cycles. Every instruction starts with a fetch step and a decode step. The decode step precomputes the branch target on the ALU. The control outputs depend on the state register alone. The opcode is examined only while leaving the decode step and the address step. There is no data stream at the edge of this block, so every pin is a plain control level without a handshake.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the machine in the fetch step, from any step.
- R2: The fetch step drives mem_rd=1, ir_load=1, pc_load=1, alu_b_sel=01, and every other control 0. The next step is always decode.
- R3: The decode step drives alu_b_sel=11 and every other control 0. The next step depends on the opcode:
  - 100011 (load) or 101011 (store) goes to the address step.
  - 000000 (register op) goes to the execute step.
  - 000100 (branch-if-equal) goes to the branch step.
  - 000010 (jump) goes to the jump step.
  - Any other value goes back to fetch.
- R4: The address step drives alu_a_reg=1 and alu_b_sel=10, with alu_mode=00 and every other control 0. The next step depends on the opcode:
  - 100011 goes to memory read.
  - 101011 goes to memory write.
  - Any other value goes to fetch.
- R5: The memory-read step drives mem_rd=1 and addr_from_alu=1, and every other control 0. The next step is load write-back. A load takes 5 cycles.
- R6: The load write-back step drives rf_wr=1, wb_from_mem=1 and rf_dst_rd=0, and every other control 0. The next step is fetch.
- R7: The memory-write step drives mem_wr=1 and addr_from_alu=1, and every other control 0. The next step is fetch. A store takes 4 cycles.
- R8: The execute step drives alu_a_reg=1, alu_b_sel=00 and alu_mode=10, with every other control 0. It is followed by the register write-back step. That step drives rf_wr=1, rf_dst_rd=1 and wb_from_mem=0, with every other control 0, and then goes to fetch. A register op takes 4 cycles.
- R9: The branch step drives alu_a_reg=1, alu_b_sel=00, alu_mode=01, pc_load_if_zero=1 and pc_next_sel=01, with every other control 0. It then goes to fetch, so a branch takes 3 cycles.
- R10: The jump step drives pc_load=1 and pc_next_sel=10, with every other control 0. It then goes to fetch, so a jump takes 3 cycles.
- R11: A change of opcode in any step other than decode and address has no effect on the sequence or on the outputs.
- R12: mem_rd and mem_wr are never both 1. pc_load and pc_load_if_zero are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Opcode field of the instruction register |
| pc_load | output | 1 | Unconditional program-counter load |
| pc_load_if_zero | output | 1 | Program-counter load qualified by the ALU zero flag |
| addr_from_alu | output | 1 | Memory address from ALU result register (0: from PC) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| wb_from_mem | output | 1 | Register write data from memory data register (0: from ALU result) |
| ir_load | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Write destination is the rd field (0: rt field) |
| alu_a_reg | output | 1 | ALU operand A from register A (0: from PC) |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 function field |
| pc_next_sel | output | 2 | Next PC: 00 ALU output, 01 ALU result register, 10 jump target |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the five standard opcode codes. With these values the bench can reach every decode branch by picking each listed code directly, and it covers the "unknown opcode" path with random values drawn from the remaining 59 codes. Since the opcode changes freely in every cycle, the random run reaches the steps where the opcode must be ignored. Resets injected mid-instruction return the machine to fetch from steps other than the idle one.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MRD    = 4'd3,
    ST_MWB    = 4'd4,
    ST_MWR    = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BR     = 4'd8,
    ST_JMP    = 4'd9
  } mcf_state_e;

  localparam logic [1:0] BSEL_REG    = 2'b00;
  localparam logic [1:0] BSEL_FOUR   = 2'b01;
  localparam logic [1:0] BSEL_IMM    = 2'b10;
  localparam logic [1:0] BSEL_IMM_SH = 2'b11;

  localparam logic [1:0] MODE_ADD  = 2'b00;
  localparam logic [1:0] MODE_SUB  = 2'b01;
  localparam logic [1:0] MODE_FUNC = 2'b10;

  localparam logic [1:0] PCSEL_ALU    = 2'b00;
  localparam logic [1:0] PCSEL_TARGET = 2'b01;
  localparam logic [1:0] PCSEL_JUMP   = 2'b10;

  typedef struct packed {
    logic       pc_load;
    logic       pc_load_if_zero;
    logic       addr_from_alu;
    logic       mem_rd;
    logic       mem_wr;
    logic       wb_from_mem;
    logic       ir_load;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       alu_a_reg;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_mode;
    logic [1:0] pc_next_sel;
  } mcf_ctrl_t;

endpackage

// File: rtl/mcf_next.sv
module mcf_next
  import mcf_pkg::*;
#(
  parameter int              OPC_W    = 6,
  parameter logic [OPC_W-1:0] OP_ALU  = 6'b000000,
  parameter logic [OPC_W-1:0] OP_JUMP = 6'b000010,
  parameter logic [OPC_W-1:0] OP_BEQ  = 6'b000100,
  parameter logic [OPC_W-1:0] OP_LOAD = 6'b100011,
  parameter logic [OPC_W-1:0] OP_STORE = 6'b101011
) (
  input  mcf_state_e       cur,
  input  logic [OPC_W-1:0] opcode,
  output mcf_state_e       nxt
);

  logic is_load, is_store, is_alu, is_beq, is_jump;

  always_comb begin
    is_load  = (opcode == OP_LOAD);
    is_store = (opcode == OP_STORE);
    is_alu   = (opcode == OP_ALU);
    is_beq   = (opcode == OP_BEQ);
    is_jump  = (opcode == OP_JUMP);
  end

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (is_load || is_store) nxt = ST_ADDR;
        else if (is_alu)         nxt = ST_EXEC;
        else if (is_beq)         nxt = ST_BR;
        else if (is_jump)        nxt = ST_JMP;
        else                     nxt = ST_FETCH;
      end
      ST_ADDR: begin
        if (is_load)       nxt = ST_MRD;
        else if (is_store) nxt = ST_MWR;
        else               nxt = ST_FETCH;
      end
      ST_MRD:  nxt = ST_MWB;
      ST_EXEC: nxt = ST_RWB;
      ST_MWB, ST_MWR, ST_RWB, ST_BR, ST_JMP: nxt = ST_FETCH;
      default: nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcf_decode.sv
module mcf_decode
  import mcf_pkg::*;
(
  input  mcf_state_e cur,
  output mcf_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (cur)
      ST_FETCH: begin
        ctrl.mem_rd      = 1'b1;
        ctrl.ir_load     = 1'b1;
        ctrl.pc_load     = 1'b1;
        ctrl.alu_b_sel   = BSEL_FOUR;
        ctrl.alu_mode    = MODE_ADD;
        ctrl.pc_next_sel = PCSEL_ALU;
      end
      ST_DECODE: begin
        ctrl.alu_b_sel = BSEL_IMM_SH;
        ctrl.alu_mode  = MODE_ADD;
      end
      ST_ADDR: begin
        ctrl.alu_a_reg = 1'b1;
        ctrl.alu_b_sel = BSEL_IMM;
        ctrl.alu_mode  = MODE_ADD;
      end
      ST_MRD: begin
        ctrl.mem_rd        = 1'b1;
        ctrl.addr_from_alu = 1'b1;
      end
      ST_MWB: begin
        ctrl.rf_wr       = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      ST_MWR: begin
        ctrl.mem_wr        = 1'b1;
        ctrl.addr_from_alu = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alu_a_reg = 1'b1;
        ctrl.alu_b_sel = BSEL_REG;
        ctrl.alu_mode  = MODE_FUNC;
      end
      ST_RWB: begin
        ctrl.rf_wr     = 1'b1;
        ctrl.rf_dst_rd = 1'b1;
      end
      ST_BR: begin
        ctrl.alu_a_reg       = 1'b1;
        ctrl.alu_b_sel       = BSEL_REG;
        ctrl.alu_mode        = MODE_SUB;
        ctrl.pc_load_if_zero = 1'b1;
        ctrl.pc_next_sel     = PCSEL_TARGET;
      end
      ST_JMP: begin
        ctrl.pc_load     = 1'b1;
        ctrl.pc_next_sel = PCSEL_JUMP;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcf_pkg::*;
#(
  parameter int               OPC_W    = 6,
  parameter logic [OPC_W-1:0] OP_ALU   = 6'b000000,
  parameter logic [OPC_W-1:0] OP_JUMP  = 6'b000010,
  parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OPC_W-1:0] OP_STORE = 6'b101011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_load,
  output logic             pc_load_if_zero,
  output logic             addr_from_alu,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             wb_from_mem,
  output logic             ir_load,
  output logic             rf_wr,
  output logic             rf_dst_rd,
  output logic             alu_a_reg,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_mode,
  output logic [1:0]       pc_next_sel
);

  mcf_state_e state_q, state_d;
  mcf_ctrl_t  ctrl;

  mcf_next #(
    .OPC_W(OPC_W), .OP_ALU(OP_ALU), .OP_JUMP(OP_JUMP),
    .OP_BEQ(OP_BEQ), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)
  ) u_next (
    .cur    (state_q),
    .opcode (opcode),
    .nxt    (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  mcf_decode u_decode (
    .cur  (state_q),
    .ctrl (ctrl)
  );

  always_comb begin
    pc_load         = ctrl.pc_load;
    pc_load_if_zero = ctrl.pc_load_if_zero;
    addr_from_alu   = ctrl.addr_from_alu;
    mem_rd          = ctrl.mem_rd;
    mem_wr          = ctrl.mem_wr;
    wb_from_mem     = ctrl.wb_from_mem;
    ir_load         = ctrl.ir_load;
    rf_wr           = ctrl.rf_wr;
    rf_dst_rd       = ctrl.rf_dst_rd;
    alu_a_reg       = ctrl.alu_a_reg;
    alu_b_sel       = ctrl.alu_b_sel;
    alu_mode        = ctrl.alu_mode;
    pc_next_sel     = ctrl.pc_next_sel;
  end

  assert_reset_to_fetch_R1: assert property (@(posedge clk)
    rst |=> (ir_load && pc_load));

  assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

  assert_decode_alu_dispatch_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE && opcode == OP_ALU) |=> (alu_mode == MODE_FUNC));

  assert_memrd_then_wb_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_from_alu) |=> (rf_wr && wb_from_mem));

  assert_exec_ignores_opcode_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC) |=> (rf_wr && rf_dst_rd));

  assert_last_step_returns_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {ST_MWB, ST_MWR, ST_RWB, ST_BR, ST_JMP}) |=> ir_load);

  assert_mem_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_pc_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(pc_load && pc_load_if_zero));

endmodule

// File: tb/mc_ctrl_fsm_bench.sv
module mc_ctrl_fsm_bench;

  localparam logic [5:0] C_ALU = 6'b000000, C_JMP = 6'b000010, C_BEQ = 6'b000100,
                         C_LD = 6'b100011, C_ST = 6'b101011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr, wb_from_mem;
  logic ir_load, rf_wr, rf_dst_rd, alu_a_reg;
  logic [1:0] alu_b_sel, alu_mode, pc_next_sel;

  int checks = 0;
  int fails = 0;
  int model = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mc_ctrl_fsm u_mc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .wb_from_mem(wb_from_mem), .ir_load(ir_load), .rf_wr(rf_wr),
    .rf_dst_rd(rf_dst_rd), .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel),
    .alu_mode(alu_mode), .pc_next_sel(pc_next_sel)
  );

  function automatic logic [15:0] got_vec();
    return {pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr, wb_from_mem,
            ir_load, rf_wr, rf_dst_rd, alu_a_reg, alu_b_sel, alu_mode, pc_next_sel};
  endfunction

  // order: pcl pcz adr rd wr wbm irl rfw dst a b[2] mode[2] pcsel[2]
  function automatic logic [15:0] exp_vec(int s);
    case (s)
      0: return 16'b1001001000_01_00_00;
      1: return 16'b0000000000_11_00_00;
      2: return 16'b0000000001_10_00_00;
      3: return 16'b0011000000_00_00_00;
      4: return 16'b0000010100_00_00_00;
      5: return 16'b0010100000_00_00_00;
      6: return 16'b0000000001_00_10_00;
      7: return 16'b0000000110_00_00_00;
      8: return 16'b0100000001_00_01_01;
      9: return 16'b1000000000_00_00_10;
      default: return 16'hffff;
    endcase
  endfunction

  function automatic int nxt(int s, logic [5:0] op);
    case (s)
      0: return 1;
      1: if (op == C_LD || op == C_ST) return 2;
         else if (op == C_ALU) return 6;
         else if (op == C_BEQ) return 8;
         else if (op == C_JMP) return 9;
         else return 0;
      2: if (op == C_LD) return 3; else if (op == C_ST) return 5; else return 0;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6, 7: return "R8";
      8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_out(string tag);
    logic [15:0] g, e;
    g = got_vec();
    e = exp_vec(model);
    checks++;
    if (g !== e) begin
      fails++;
      $display("FAIL %s step %0d: got %b expected %b", tag, model, g, e);
    end
  endtask

  // called at a negedge: drive, advance model, wait one cycle, check
  task automatic step(logic r, logic [5:0] op, string tag);
    rst = r;
    opcode = op;
    model = r ? 0 : nxt(model, op);
    @(negedge clk);
    check_out(tag == "" ? tag_of(model) : tag);
  endtask

  task automatic run_class(logic [5:0] op, int len, string tag);
    int n = 0;
    do begin
      step(1'b0, op, "");
      n++;
    end while (!ir_load && n < 10);
    checks++;
    if (n != len) begin
      fails++;
      $display("FAIL %s cycle count: got %0d expected %0d", tag, n, len);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1;
    model = 0;
    @(negedge clk);
    @(negedge clk);
    check_out("R1");
    step(1'b1, C_LD, "R1");

    run_class(C_LD, 5, "R5");
    run_class(C_ST, 4, "R7");
    run_class(C_ALU, 4, "R8");
    run_class(C_BEQ, 3, "R9");
    run_class(C_JMP, 3, "R10");
    run_class(6'b111111, 2, "R3");
    // address step with an opcode that is neither load nor store: R4
    step(1'b0, C_LD, "");
    step(1'b0, C_LD, "");
    step(1'b0, C_JMP, "R4");

    // R11: opcode changes after the address step do not alter the load path
    step(1'b0, C_LD, "");
    step(1'b0, C_LD, "");
    step(1'b0, C_LD, "");
    step(1'b0, C_JMP, "R11");
    step(1'b0, C_BEQ, "R11");
    // R11: register op with opcode changed during execute
    step(1'b0, C_ALU, "");
    step(1'b0, C_ALU, "");
    step(1'b0, C_ST, "R11");
    step(1'b0, C_LD, "R11");

    // R1: reset from the middle of a load
    step(1'b0, C_LD, "");
    step(1'b0, C_LD, "");
    step(1'b0, C_LD, "");
    step(1'b1, C_LD, "R1");

    for (int i = 0; i < 4000; i++) begin
      logic [5:0] op;
      logic r;
      case ($urandom % 6)
        0: op = C_ALU;
        1: op = C_JMP;
        2: op = C_BEQ;
        3: op = C_LD;
        4: op = C_ST;
        default: op = 6'($urandom);
      endcase
      r = (($urandom % 64) == 0);
      step(r, op, r ? "R1" : "");
      checks++;
      if ((mem_rd && mem_wr) || (pc_load && pc_load_if_zero)) begin
        fails++;
        $display("FAIL R12: got rd=%b wr=%b pcl=%b pcz=%b expected no overlap",
                 mem_rd, mem_wr, pc_load, pc_load_if_zero);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule